// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This core keeps wall-clock time (seconds, minutes, hours) and a calendar date (day, month, year offset, leap flag) and advances them once per second. The second is formed by counting single-cycle pulses of a slow oscillator enable, nominally 32768 per second. Software reaches the clock through a 32-bit register port. The port holds a keyed control register, an oscillator status register, a packed time register and a packed date register.

Writes to the time and date registers do not take effect at once. Each of these two registers has its own transfer slot. A slot holds the written word for a fixed number of cycles, models the crossing into the slow domain, and then loads the counters. While a slot is pending, a busy flag in the control register is raised. Software polls the flag before its next write, because a write to a busy register is dropped. Software also supplies the leap flag of the date, and this flag alone sets the length of February.

The register port has a request channel and a response channel. `req_ready` is held high, so every request is taken in the cycle that `req_valid` is high. Each read returns exactly one response: `rsp_valid` rises in the cycle after the read is taken. The response channel has no back-pressure, so the consumer must accept it in that cycle. Writes give no response.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read as follows: control 0, status 0, time 0 (00:00:00), and date 0x00000101 (day 1, month 1, year offset 0, leap flag clear).
- R2: A write to the control register (offset 0x00) is stored only when bits 31:16 of the write data equal 0x16AA. Any other control write leaves the register unchanged.
- R3: The control register stores bit 0 (external oscillator select), bit 3 (drive strength) and bit 14 (automatic source switching). On reads, bit 7 shows the time slot busy, bit 8 shows the date slot busy, and bit 9 shows that either slot is busy. All other bits read 0.
- R4: Bit 0 of the status register (offset 0x04) reads 1 when the external oscillator is driving the tick. That is the case when the select bit is set and either automatic switching is off or `ext_osc_good` is high. All other bits read 0.
- R5: A write to time (offset 0x10) or date (offset 0x14) that is accepted loads the counters COMMIT_DLY cycles later. Its busy flag is set for that whole time, and the old value stays readable until the load.
- R6: A write to a time or date register whose busy flag is set is dropped.
- R7: The time register holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. The date register holds day in bits 4:0, month in bits 11:8, year offset (from 2010) in bits 21:16 and the leap flag in bit 22. All other bits are ignored on write and read as 0.
- R8: When a second elapses at 23:59:59, the time becomes 00:00:00 and the date advances on the same clock edge.
- R9: The seconds count advances once for every TICK_DIV cycles in which `osc_pulse` is high. Seconds carry into minutes at 59, and minutes carry into hours at 59.
- R10: The last day of a month is 29 for February with the leap flag set, 28 for February with it clear, 30 for months 4, 6, 9 and 11, and 31 for the rest. After the last day of month 12 the date goes to January 1 and the year offset increments, wrapping from 63 to 0. The leap flag is left unchanged.
- R11: `req_ready` is always high. A read returns `rsp_valid` with data one cycle after it is taken. A write returns no response. An unmapped offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_pulse | input | 1 | One-cycle enable per slow oscillator period |
| ext_osc_good | input | 1 | External oscillator judged running |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request taken (always high) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |

## Verification
The bench drives the date rollover at every distinct month end: April 30, February 28 and February 29 with and without the leap flag, January 31, December 31, and the year-offset wrap. A wrong month-length table would skip a day or produce day 31 in a 30-day month. It counts oscillator pulses one short of a second to catch a divider that is off by one. It issues back-to-back time writes to show that a design which overwrites a pending slot loads the second value instead of the first. It also sends keyless control writes and writes with reserved bits set, which a loose decode would store.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_TIME = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DATE = 8'h14;

  localparam int SLOT_TIME = 0;
  localparam int SLOT_DATE = 1;
  localparam int NUM_SLOTS = 2;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] year;
    logic [3:0] mon;
    logic [4:0] day;
  } rtc_date_t;

  typedef struct packed {
    logic auto_sw;
    logic drive;
    logic ext_sel;
  } rtc_ctrl_t;

  function automatic logic [DATA_W-1:0] time_to_word(rtc_time_t t);
    return {11'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
  endfunction

  function automatic rtc_time_t word_to_time(logic [DATA_W-1:0] w);
    rtc_time_t t;
    t.hour = w[20:16];
    t.min  = w[13:8];
    t.sec  = w[5:0];
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] date_to_word(rtc_date_t d);
    return {9'b0, d.leap, d.year, 4'b0, d.mon, 3'b0, d.day};
  endfunction

  function automatic rtc_date_t word_to_date(logic [DATA_W-1:0] w);
    rtc_date_t d;
    d.leap = w[22];
    d.year = w[21:16];
    d.mon  = w[11:8];
    d.day  = w[4:0];
    return d;
  endfunction

  function automatic logic [4:0] month_last_day(logic [3:0] mon, logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic sec_tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign sec_tick_o = pulse_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (sec_tick_o) cnt_q <= '0;
    else if (pulse_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_commit_slot.sv
module rtc_commit_slot #(
  parameter int DLY = 4,
  parameter int W   = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         commit_o,
  output logic [W-1:0] data_o
);
  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;

  logic [CW-1:0] cnt_q;

  assign commit_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      data_o <= '0;
    end else if (load_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(DLY - 1);
      data_o <= data_i;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_tick_i,
  input  logic      time_ld_i,
  input  rtc_time_t time_i,
  input  logic      date_ld_i,
  input  rtc_date_t date_i,
  output rtc_time_t time_o,
  output rtc_date_t date_o
);
  localparam rtc_date_t DATE_RST = '{leap: 1'b0, year: 6'd0, mon: 4'd1, day: 5'd1};

  rtc_time_t t_next;
  rtc_date_t d_next;
  logic      day_carry;

  always_comb begin
    t_next    = time_o;
    day_carry = 1'b0;
    if (time_o.sec >= 6'd59) begin
      t_next.sec = '0;
      if (time_o.min >= 6'd59) begin
        t_next.min = '0;
        if (time_o.hour >= 5'd23) begin
          t_next.hour = '0;
          day_carry   = 1'b1;
        end else begin
          t_next.hour = time_o.hour + 1'b1;
        end
      end else begin
        t_next.min = time_o.min + 1'b1;
      end
    end else begin
      t_next.sec = time_o.sec + 1'b1;
    end
  end

  always_comb begin
    d_next = date_o;
    if (date_o.day >= month_last_day(date_o.mon, date_o.leap)) begin
      d_next.day = 5'd1;
      if (date_o.mon >= 4'd12) begin
        d_next.mon  = 4'd1;
        d_next.year = date_o.year + 1'b1;
      end else begin
        d_next.mon = date_o.mon + 1'b1;
      end
    end else begin
      d_next.day = date_o.day + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_o <= '0;
      date_o <= DATE_RST;
    end else begin
      if (time_ld_i)       time_o <= time_i;
      else if (sec_tick_i) time_o <= t_next;
      if (date_ld_i)                                     date_o <= date_i;
      else if (sec_tick_i && day_carry && !time_ld_i)    date_o <= d_next;
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int          TICK_DIV   = 32768,
  parameter int          COMMIT_DLY = 8,
  parameter logic [15:0] CTRL_KEY   = 16'h16AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_pulse,
  input  logic              ext_osc_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic                 sec_tick;
  rtc_ctrl_t            ctrl_q;
  logic [2:0]           ctrl_bits;
  rtc_time_t            time_q;
  rtc_date_t            date_q;
  logic [DATA_W-1:0]    time_word;
  logic [DATA_W-1:0]    date_word;
  logic [NUM_SLOTS-1:0] slot_ld, slot_busy, slot_commit;
  logic [DATA_W-1:0]    slot_in  [NUM_SLOTS];
  logic [DATA_W-1:0]    slot_out [NUM_SLOTS];
  logic                 wr_ctrl, rd_req, active_ext;
  logic [DATA_W-1:0]    rd_mux;

  assign req_ready = 1'b1;
  assign rd_req    = req_valid && !req_we;
  assign wr_ctrl   = req_valid && req_we && (req_addr == OFS_CTRL)
                     && (req_wdata[31:16] == CTRL_KEY);
  assign slot_ld[SLOT_TIME] = req_valid && req_we && (req_addr == OFS_TIME);
  assign slot_ld[SLOT_DATE] = req_valid && req_we && (req_addr == OFS_DATE);
  assign slot_in[SLOT_TIME] = time_to_word(word_to_time(req_wdata));
  assign slot_in[SLOT_DATE] = date_to_word(word_to_date(req_wdata));

  rtc_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .pulse_i(osc_pulse), .sec_tick_o(sec_tick)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    rtc_commit_slot #(.DLY(COMMIT_DLY), .W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load_i(slot_ld[i]), .data_i(slot_in[i]),
      .busy_o(slot_busy[i]), .commit_o(slot_commit[i]), .data_o(slot_out[i])
    );
  end

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick),
    .time_ld_i(slot_commit[SLOT_TIME]), .time_i(word_to_time(slot_out[SLOT_TIME])),
    .date_ld_i(slot_commit[SLOT_DATE]), .date_i(word_to_date(slot_out[SLOT_DATE])),
    .time_o(time_q), .date_o(date_q)
  );

  assign time_word  = time_to_word(time_q);
  assign date_word  = date_to_word(date_q);
  assign ctrl_bits  = ctrl_q;
  assign active_ext = ctrl_q.ext_sel && (ext_osc_good || !ctrl_q.auto_sw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= '{auto_sw: req_wdata[14], drive: req_wdata[3],
                                  ext_sel: req_wdata[0]};
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      OFS_CTRL: begin
        rd_mux[0]  = ctrl_q.ext_sel;
        rd_mux[3]  = ctrl_q.drive;
        rd_mux[14] = ctrl_q.auto_sw;
        rd_mux[7]  = slot_busy[SLOT_TIME];
        rd_mux[8]  = slot_busy[SLOT_DATE];
        rd_mux[9]  = |slot_busy;
      end
      OFS_STAT: rd_mux[0] = active_ext;
      OFS_TIME: rd_mux = time_word;
      OFS_DATE: rd_mux = date_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
  import rtc_pkg::*;
#(
  parameter logic [15:0] CTRL_KEY = 16'h16AA
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_we,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [DATA_W-1:0]    req_wdata,
  input logic                 rsp_valid,
  input logic                 sec_tick,
  input logic [NUM_SLOTS-1:0] slot_busy,
  input logic [NUM_SLOTS-1:0] slot_commit,
  input logic [DATA_W-1:0]    time_word,
  input logic [2:0]           ctrl_bits
);
  AST_KEYLESS_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_addr == OFS_CTRL && req_wdata[31:16] != CTRL_KEY)
    |=> $stable(ctrl_bits)); // R2

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_addr == OFS_TIME && !slot_busy[SLOT_TIME])
    |=> slot_busy[SLOT_TIME]); // R5

  AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !slot_commit[SLOT_TIME]) |=> $stable(time_word)); // R5

  AST_MIDNIGHT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !slot_commit[SLOT_TIME] && time_word == 32'h00173B3B)
    |=> (time_word == '0)); // R8

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !slot_commit[SLOT_TIME] && time_word[5:0] < 6'd59)
    |=> (time_word[5:0] == 6'($past(time_word[5:0]) + 6'd1))); // R9

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid); // R11

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid); // R11
endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.CTRL_KEY(CTRL_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .sec_tick(sec_tick), .slot_busy(slot_busy), .slot_commit(slot_commit),
  .time_word(time_word), .ctrl_bits(ctrl_bits)
);

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
  localparam int TICK_DIV   = 4;
  localparam int COMMIT_DLY = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_pulse = 1'b0;
  logic        ext_osc_good = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  rtc_calendar_core #(.TICK_DIV(TICK_DIV), .COMMIT_DLY(COMMIT_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .ext_osc_good(ext_osc_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: pops expected items as responses arrive
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response: actual %h expected none", rsp_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (COMMIT_DLY + 3) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_pulse = 1'b1;
      @(negedge clk); osc_pulse = 1'b0;
    end
  endtask

  task automatic set_clock(input logic [31:0] d, input logic [31:0] t);
    bus_write(8'h14, d); settle();
    bus_write(8'h10, t); settle();
  endtask

  task automatic rollover(input logic [31:0] d, input logic [31:0] exp_d, input string t);
    set_clock(d, 32'h00173B3B);
    pulses(TICK_DIV);
    bus_read(8'h10, 32'h0, {t, " time"});
    bus_read(8'h14, exp_d, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_read(8'h00, 32'h0, "R1 ctrl reset");
    bus_read(8'h04, 32'h0, "R1 status reset");
    bus_read(8'h10, 32'h0, "R1 time reset");
    bus_read(8'h14, 32'h00000101, "R1 date reset");

    bus_write(8'h00, 32'h0000_4009);
    bus_read(8'h00, 32'h0, "R2 keyless ctrl ignored");
    bus_write(8'h00, 32'h16AA_FFFF);
    bus_read(8'h00, 32'h0000_4009, "R3 ctrl stored bits only");
    bus_write(8'h00, 32'h16AB_0000);
    bus_read(8'h00, 32'h0000_4009, "R2 wrong key ignored");

    ext_osc_good = 1'b0;
    bus_read(8'h04, 32'h0, "R4 auto switch falls back");
    ext_osc_good = 1'b1;
    bus_read(8'h04, 32'h1, "R4 external active");
    bus_write(8'h00, 32'h16AA_0001);
    ext_osc_good = 1'b0;
    bus_read(8'h04, 32'h1, "R4 no auto switch keeps external");

    bus_write(8'h10, 32'h0012_2A05);
    bus_read(8'h00, 32'h0000_0281, "R3 R5 time busy flags");
    bus_read(8'h10, 32'h0, "R5 old time until commit");
    settle();
    bus_read(8'h00, 32'h0000_0001, "R5 busy cleared");
    bus_read(8'h10, 32'h0012_2A05, "R5 time committed");

    bus_write(8'h14, 32'h0003_0709);
    bus_read(8'h00, 32'h0000_0301, "R3 date busy flags");
    settle();

    bus_write(8'h10, 32'h0001_0203);
    bus_write(8'h10, 32'h0004_0506);
    settle();
    bus_read(8'h10, 32'h0001_0203, "R6 write while busy dropped");

    bus_write(8'h10, 32'hFFE0_C0C0 | 32'h0005_0A0B);
    settle();
    bus_read(8'h10, 32'h0005_0A0B, "R7 time reserved bits zero");
    bus_write(8'h14, 32'hFF80_F0E0 | 32'h0005_0A0C);
    settle();
    bus_read(8'h14, 32'h0005_0A0C, "R7 date reserved bits zero");

    bus_write(8'h10, 32'h0000_0005); settle();
    pulses(TICK_DIV - 1);
    bus_read(8'h10, 32'h0000_0005, "R9 no tick one pulse short");
    pulses(1);
    bus_read(8'h10, 32'h0000_0006, "R9 second advanced");
    bus_write(8'h10, 32'h0001_0A3B); settle();
    pulses(TICK_DIV);
    bus_read(8'h10, 32'h0001_0B00, "R9 minute carry");

    rollover(32'h0005_041E, 32'h0005_0501, "R8 R10 April 30");
    rollover(32'h0046_021C, 32'h0046_021D, "R10 Feb 28 leap");
    rollover(32'h0046_021D, 32'h0046_0301, "R10 Feb 29 leap");
    rollover(32'h0007_021C, 32'h0007_0301, "R10 Feb 28 common");
    rollover(32'h0001_011F, 32'h0001_0201, "R10 Jan 31");
    rollover(32'h000A_0C1F, 32'h000B_0101, "R10 Dec 31");
    rollover(32'h003F_0C1F, 32'h0000_0101, "R10 year wrap");

    bus_read(8'h08, 32'h0, "R11 unmapped reads zero");
    checks++;
    if (req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 ready: actual %b expected 1", req_ready);
    end

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule